// File: doc/BRIEF.md
# Overcurrent Fault Timing Sequencer

This block is the digital sequencer for a single load switch on a supply rail. It receives five status inputs: supply healthy, enable, current limit engaged, pass transistor fully on, and die too hot. It drives three outputs: a switch-on command, an output-discharge command and an active-low fault flag. Every status input passes through a two-stage synchroniser before the state machine uses it.

When the current limit engages, the block starts a timer. A short overload is allowed to pass. If the limit is still engaged when the timer expires, the switch is turned off and the fault flag is pulled low. A build option sets what happens after that:

- **Latch mode**: the switch stays off until enable is withdrawn or the supply drops.
- **Retry mode**: the switch is turned on again each time a long retry period ends.

Faults are masked during turn-on until the transistor reports fully on. An over-temperature event turns the switch off but never raises the fault flag.

Top module: `oc_fault_sequencer`

## Requirements
- R1: While `supply_ok` is low the switch is off, `discharge` is high and `fault_n` is high (released). A drop of `supply_ok` takes effect after the third rising clock edge, and it also clears a latched fault.
- R2: The switch turns on only when the supply is healthy and enable is in its asserted level. `ENABLE_HIGH`=1 means `enable_in` high is asserted; `ENABLE_HIGH`=0 means low is asserted. `switch_on` rises after the third rising edge following the qualifying input change.
- R3: If `ilim_active` is held high for more than `LIMIT_CYCLES` clock cycles while the switch is on, `switch_on` falls and `fault_n` falls. This happens after rising edge 3+`LIMIT_CYCLES`, counted from the edge at which `ilim_active` is first sampled high.
- R4: A current-limit episode of `LIMIT_CYCLES` cycles or fewer leaves the switch on and `fault_n` high.
- R5: In latch mode (`AUTO_RETRY`=0), once faulted, the switch stays off and `fault_n` stays low while enable and supply stay good. Withdrawing enable or dropping the supply releases `fault_n` and allows a fresh turn-on.
- R6: In retry mode (`AUTO_RETRY`=1), the switch turns on again `RETRY_CYCLES` cycles after each fault turn-off. `fault_n` stays low across retries while the overload persists. It returns high once the switch is on and out of current limit.
- R7: After turn-on, while `fet_enhanced` is low, `ilim_active` is ignored. No timer runs and no fault is raised.
- R8: `over_temp` high turns the switch off without ever pulling `fault_n` low, even during a current-limit episode. When `over_temp` falls, the switch turns on again.
- R9: `discharge` is high exactly when `switch_on` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, driven by power-on reset |
| supply_ok | input | 1 | Supply is above the undervoltage threshold |
| enable_in | input | 1 | Enable request, polarity set by `ENABLE_HIGH` |
| ilim_active | input | 1 | Current-limit loop is regulating |
| fet_enhanced | input | 1 | Pass transistor is fully on |
| over_temp | input | 1 | Die-temperature comparator output (hysteresis applied upstream) |
| switch_on | output | 1 | Turn-on command to the gate driver |
| discharge | output | 1 | Output pull-down command |
| fault_n | output | 1 | Fault flag, active low; high means released |

## Verification
The bound checker watches the following on every cycle:
- a supply drop or enable drop forces the switch off on the next edge;
- a rising switch command is always preceded by a qualified go condition;
- the fault flag only falls out of a current-limit episode;
- over-temperature never lowers the flag;
- blanking never lowers the flag;
- the current-limit state never lasts longer than the limit window;
- in latch mode, a raised flag holds while go holds.

The exact expiry edge, the boundary between `LIMIT_CYCLES` and `LIMIT_CYCLES`+1 cycles of overload, and the retry timing across two retries are shown only by the bench. So are the recovery paths through enable and supply, and the differing behaviour of the latch and retry builds under the same stimulus.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

   // One-hot controller states
   typedef enum logic [5:0] {
      ST_OFF   = 6'b000001,
      ST_BLANK = 6'b000010,
      ST_ON    = 6'b000100,
      ST_LIMIT = 6'b001000,
      ST_FAULT = 6'b010000,
      ST_HOT   = 6'b100000
   } ofs_state_e;

   // Positions of the status inputs in the synchroniser vector
   localparam int IN_W    = 5;
   localparam int IX_SUP  = 0;
   localparam int IX_EN   = 1;
   localparam int IX_ILIM = 2;
   localparam int IX_FET  = 3;
   localparam int IX_OT   = 4;

endpackage

// File: rtl/ofs_sync.sv
module ofs_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk) begin
      if (rst) stg <= '0;
      else     stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/ofs_timer.sv
module ofs_timer #(
   parameter int unsigned CYCLES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic done
);

   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)               cnt <= '0;
      else if (start)        cnt <= CW'(CYCLES - 1);
      else if (cnt != '0)    cnt <= cnt - CW'(1);
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/oc_fault_sequencer.sv
module oc_fault_sequencer #(
   parameter int unsigned CLK_HZ       = 1_000_000,
   parameter int unsigned LIMIT_CYCLES = CLK_HZ / 1000 * 12,
   parameter int unsigned RETRY_CYCLES = CLK_HZ,
   parameter bit          ENABLE_HIGH  = 1'b1,
   parameter bit          AUTO_RETRY   = 1'b0,
   parameter int          SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic supply_ok,
   input  logic enable_in,
   input  logic ilim_active,
   input  logic fet_enhanced,
   input  logic over_temp,
   output logic switch_on,
   output logic discharge,
   output logic fault_n
);
   import ofs_pkg::*;

   // Elaboration-time parameter checks
   if (LIMIT_CYCLES < 2) begin : g_bad_limit
      $error("LIMIT_CYCLES must be at least 2");
   end
   if (RETRY_CYCLES < 2) begin : g_bad_retry
      $error("RETRY_CYCLES must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   // Input synchronisation
   logic [IN_W-1:0] raw_in, syn_in;
   assign raw_in[IX_SUP]  = supply_ok;
   assign raw_in[IX_EN]   = enable_in;
   assign raw_in[IX_ILIM] = ilim_active;
   assign raw_in[IX_FET]  = fet_enhanced;
   assign raw_in[IX_OT]   = over_temp;

   ofs_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw_in),
      .q   (syn_in)
   );

   logic s_sup, s_en_act, s_ilim, s_fet, s_ot, go;
   assign s_sup  = syn_in[IX_SUP];
   assign s_ilim = syn_in[IX_ILIM];
   assign s_fet  = syn_in[IX_FET];
   assign s_ot   = syn_in[IX_OT];

   if (ENABLE_HIGH) begin : g_en_high
      assign s_en_act = syn_in[IX_EN];
   end else begin : g_en_low
      assign s_en_act = ~syn_in[IX_EN];
   end

   assign go = s_sup & s_en_act;

   // Timers
   ofs_state_e st, nxt;
   logic       lim_start, lim_done, rty_start, rty_done;

   ofs_timer #(.CYCLES(LIMIT_CYCLES)) u_lim_tmr (
      .clk   (clk),
      .rst   (rst),
      .start (lim_start),
      .done  (lim_done)
   );

   if (AUTO_RETRY) begin : g_retry
      ofs_timer #(.CYCLES(RETRY_CYCLES)) u_rty_tmr (
         .clk   (clk),
         .rst   (rst),
         .start (rty_start),
         .done  (rty_done)
      );
   end else begin : g_latch
      assign rty_done = 1'b0;
   end

   // Next-state logic
   always_comb begin
      nxt = st;
      unique case (st)
         ST_OFF:   if (go && !s_ot) nxt = ST_BLANK;
         ST_BLANK: begin
            if (!go)        nxt = ST_OFF;
            else if (s_ot)  nxt = ST_HOT;
            else if (s_fet) nxt = ST_ON;
         end
         ST_ON: begin
            if (!go)         nxt = ST_OFF;
            else if (s_ot)   nxt = ST_HOT;
            else if (s_ilim) nxt = ST_LIMIT;
         end
         ST_LIMIT: begin
            if (!go)           nxt = ST_OFF;
            else if (s_ot)     nxt = ST_HOT;
            else if (!s_ilim)  nxt = ST_ON;
            else if (lim_done) nxt = ST_FAULT;
         end
         ST_FAULT: begin
            if (!go)           nxt = ST_OFF;
            else if (rty_done) nxt = ST_BLANK;
         end
         ST_HOT: begin
            if (!go)       nxt = ST_OFF;
            else if (!s_ot) nxt = ST_BLANK;
         end
         default: nxt = ST_OFF;
      endcase
   end

   assign lim_start = (nxt == ST_LIMIT) && (st != ST_LIMIT);
   assign rty_start = (nxt == ST_FAULT) && (st != ST_FAULT);

   // State and fault flag registers
   logic fault_hold;

   always_ff @(posedge clk) begin
      if (rst) begin
         st         <= ST_OFF;
         fault_hold <= 1'b0;
      end else begin
         st <= nxt;
         if (nxt == ST_FAULT)                 fault_hold <= 1'b1;
         else if (nxt == ST_OFF)              fault_hold <= 1'b0;
         else if (st == ST_ON && !s_ilim)     fault_hold <= 1'b0;
      end
   end

   // Outputs
   assign switch_on = (st == ST_BLANK) || (st == ST_ON) || (st == ST_LIMIT);
   assign discharge = ~switch_on;
   assign fault_n   = ~fault_hold;

endmodule

// File: rtl/ofs_chk.sv
module ofs_chk #(
   parameter int unsigned LIMIT_CYCLES = 2,
   parameter bit          AUTO_RETRY   = 1'b0
) (
   input logic                 clk,
   input logic                 rst,
   input ofs_pkg::ofs_state_e  st,
   input logic                 s_sup,
   input logic                 go,
   input logic                 s_ilim,
   input logic                 s_ot,
   input logic                 switch_on,
   input logic                 discharge,
   input logic                 fault_n
);
   import ofs_pkg::*;

   localparam int RW = $clog2(LIMIT_CYCLES + 2);

   logic [RW-1:0] limit_run;

   always_ff @(posedge clk) begin
      if (rst)                 limit_run <= '0;
      else if (st == ST_LIMIT) limit_run <= limit_run + RW'(1);
      else                     limit_run <= '0;
   end

   // R1
   uvlo_off_chk: assert property (@(posedge clk) disable iff (rst)
      !s_sup |=> (!switch_on && fault_n));

   // R2
   go_before_on_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(switch_on) |-> $past(go));

   // R9
   discharge_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !go |=> (discharge && !switch_on));

   // R3
   fault_from_limit_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(fault_n) |-> $past(s_ilim));

   // R3
   limit_window_chk: assert property (@(posedge clk) disable iff (rst)
      limit_run <= RW'(LIMIT_CYCLES));

   // R8
   hot_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
      (s_ot && fault_n) |=> fault_n);

   // R7
   blank_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
      ((st == ST_BLANK) && fault_n) |=> fault_n);

   // R5
   latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!AUTO_RETRY && !fault_n && go) |=> (!fault_n && !switch_on));

endmodule

bind oc_fault_sequencer ofs_chk #(
   .LIMIT_CYCLES (LIMIT_CYCLES),
   .AUTO_RETRY   (AUTO_RETRY)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .st        (st),
   .s_sup     (s_sup),
   .go        (go),
   .s_ilim    (s_ilim),
   .s_ot      (s_ot),
   .switch_on (switch_on),
   .discharge (discharge),
   .fault_n   (fault_n)
);

// File: tb/sim_oc_fault_sequencer.sv
module sim_oc_fault_sequencer;

   localparam int CLK_PERIOD = 10;
   localparam int LIM        = 16;
   localparam int RTY        = 40;

   logic clk = 1'b0;
   logic rst, supply, en_raw, ilim, fet, ot;
   logic on0, dis0, fn0, on1, dis1, fn1;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // Latch build, enable active high
   oc_fault_sequencer #(
      .LIMIT_CYCLES (LIM), .RETRY_CYCLES (RTY),
      .ENABLE_HIGH (1'b1), .AUTO_RETRY (1'b0)
   ) u0 (
      .clk (clk), .rst (rst), .supply_ok (supply), .enable_in (en_raw),
      .ilim_active (ilim), .fet_enhanced (fet), .over_temp (ot),
      .switch_on (on0), .discharge (dis0), .fault_n (fn0)
   );

   // Retry build, enable active low
   oc_fault_sequencer #(
      .LIMIT_CYCLES (LIM), .RETRY_CYCLES (RTY),
      .ENABLE_HIGH (1'b0), .AUTO_RETRY (1'b1)
   ) u1 (
      .clk (clk), .rst (rst), .supply_ok (supply), .enable_in (~en_raw),
      .ilim_active (ilim), .fet_enhanced (fet), .over_temp (ot),
      .switch_on (on1), .discharge (dis1), .fault_n (fn1)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic chk_dut(input string tag, input int which,
                          input logic exp_on, input logic exp_fn);
      if (which == 0) begin
         chk({tag, " u0 switch"}, on0, exp_on);
         chk({tag, " u0 discharge R9"}, dis0, ~exp_on);
         chk({tag, " u0 fault_n"}, fn0, exp_fn);
      end else begin
         chk({tag, " u1 switch"}, on1, exp_on);
         chk({tag, " u1 discharge R9"}, dis1, ~exp_on);
         chk({tag, " u1 fault_n"}, fn1, exp_fn);
      end
   endtask

   task automatic chk_both(input string tag, input logic exp_on, input logic exp_fn);
      chk_dut(tag, 0, exp_on, exp_fn);
      chk_dut(tag, 1, exp_on, exp_fn);
   endtask

   task automatic en_cycle(input string tag);
      en_raw = 1'b0;
      step(6);
      chk_both({tag, " enable withdrawn R5"}, 1'b0, 1'b1);
      en_raw = 1'b1;
      step(6);
      chk_both({tag, " enable restored R2"}, 1'b1, 1'b1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst = 1'b1; supply = 1'b0; en_raw = 1'b0;
      ilim = 1'b0; fet = 1'b1; ot = 1'b0;
      step(4);
      rst = 1'b0;
      step(1);
      chk_both("R1 reset state", 1'b0, 1'b1);

      // R2: enable deasserted with healthy supply keeps the switch off
      supply = 1'b1;
      step(10);
      chk_both("R2 enable off", 1'b0, 1'b1);

      // R1: enable asserted but supply low keeps the switch off
      supply = 1'b0; en_raw = 1'b1;
      step(10);
      chk_both("R1 supply low", 1'b0, 1'b1);

      // R2: turn-on latency of three edges
      supply = 1'b1;
      step(2);
      chk_both("R2 before on", 1'b0, 1'b1);
      step(1);
      chk_both("R2 on edge", 1'b1, 1'b1);
      step(4);

      // R3/R4: overload width sweep
      for (int w = 1; w <= LIM + 3; w++) begin
         ilim = 1'b1;
         for (int c = 1; c <= w + 6; c++) begin
            step(1);
            if (w > LIM && c == LIM + 2) chk_both("R3 still on", 1'b1, 1'b1);
            if (w > LIM && c == LIM + 3) chk_both("R3 expiry", 1'b0, 1'b0);
            if (c == w) ilim = 1'b0;
         end
         if (w > LIM) chk_both("R3 faulted after overload", 1'b0, 1'b0);
         else         chk_both("R4 short overload tolerated", 1'b1, 1'b1);
         en_cycle("sweep");
      end

      // R6/R5: persistent overload
      ilim = 1'b1;
      for (int c = 1; c <= 2*LIM + RTY + 5; c++) begin
         step(1);
         if (c == LIM + 3)         chk_both("R3 persistent expiry", 1'b0, 1'b0);
         if (c == LIM + 2 + RTY)   chk_dut("R6 retry wait", 1, 1'b0, 1'b0);
         if (c == LIM + 3 + RTY)   chk_dut("R6 retry on", 1, 1'b1, 1'b0);
         if (c == 2*LIM + RTY + 4) chk_dut("R6 retry limiting", 1, 1'b1, 1'b0);
         if (c == 2*LIM + RTY + 5) begin
            chk_dut("R6 second expiry", 1, 1'b0, 1'b0);
            chk_dut("R5 latch holds", 0, 1'b0, 1'b0);
         end
      end
      ilim = 1'b0;
      step(2*RTY + 2*LIM + 20);
      chk_dut("R6 recovered", 1, 1'b1, 1'b1);
      chk_dut("R5 still latched", 0, 1'b0, 1'b0);
      supply = 1'b0;
      step(6);
      chk_both("R1 supply drop clears", 1'b0, 1'b1);
      supply = 1'b1;
      step(6);
      chk_both("R5 restart after supply", 1'b1, 1'b1);

      // R7: blanking while the transistor is not fully on
      en_raw = 1'b0;
      step(6);
      fet = 1'b0; ilim = 1'b1; en_raw = 1'b1;
      step(3);
      chk_both("R7 blank on", 1'b1, 1'b1);
      step(LIM + 10);
      chk_both("R7 blank no fault", 1'b1, 1'b1);
      fet = 1'b1;
      for (int c = 1; c <= LIM + 4; c++) begin
         step(1);
         if (c == LIM + 3) chk_both("R7 limit after enhance", 1'b1, 1'b1);
         if (c == LIM + 4) chk_both("R7 expiry after enhance", 1'b0, 1'b0);
      end
      ilim = 1'b0;
      en_cycle("blank");

      // R8: over-temperature
      ot = 1'b1;
      step(2);
      chk_both("R8 before hot off", 1'b1, 1'b1);
      step(1);
      chk_both("R8 hot off", 1'b0, 1'b1);
      step(20);
      chk_both("R8 hot hold", 1'b0, 1'b1);
      ot = 1'b0;
      step(2);
      chk_both("R8 before release", 1'b0, 1'b1);
      step(1);
      chk_both("R8 release", 1'b1, 1'b1);
      step(3);
      ilim = 1'b1;
      step(6);
      chk_both("R8 in limit", 1'b1, 1'b1);
      ot = 1'b1;
      step(LIM + 10);
      chk_both("R8 hot during limit", 1'b0, 1'b1);
      ilim = 1'b0; ot = 1'b0;
      step(8);
      chk_both("R8 recovered", 1'b1, 1'b1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule